// File: doc/BRIEF.md
# Compound Tuning Word Phase Generator

This block is the phase accumulator of a direct digital synthesizer whose output frequency can be an exact rational fraction M/N of the sample clock, with N not limited to a power of two. A conventional accumulator adds a fixed integer increment every clock. This block adds that increment as well, and a small counter also adds a constant correction on top of the increment once every B steps. With a suitable set of increment, correction and period, one output cycle of N samples ends exactly on the 2^32 wrap point.

A load strobe captures the three tuning fields together. The accumulator then restarts from phase 0 with the correction counter cleared. Each cycle the block presents the full 32-bit phase. It also presents the upper bits of that phase as the address for a phase-to-amplitude table. A valid flag marks the phase as meaningful once a configuration has been loaded.

Top module: `cpg_top`

## Requirements
- R1: While reset is asserted and after it is released, until the first load, `phase_o` and `addr_o` are 0 and `valid_o` is 0.
- R2: On every clock edge where `load_i` is high, `inc_i`, `corr_i` and `period_i` are captured, and `phase_o` becomes 0 and `valid_o` becomes 1 after that edge. If the strobe is held, the phase stays at 0.
- R3: After a load, every clock edge without a load advances the phase by the captured increment plus any correction, modulo 2^32.
- R4: With period B > 0, sample k after a load (k = 0 is the cycle right after the strobe) equals (k·X + floor(k/B)·A) mod 2^32. The correction is added on steps B, 2B, 3B and so on.
- R5: With X = 429496729, A = 3 and B = 5, samples 4, 5 and 9 equal 4X, 5X+3 and 9X+3. Every tenth sample equals exactly 0, over many output periods.
- R6: With A = 0, the phase is k·X mod 2^32 for any B, as in a plain accumulator.
- R7: With B = 0, no correction is ever added, whatever the value of A.
- R8: `addr_o` equals the top ADDR_W bits of `phase_o` in the same cycle.
- R9: The approximating set X = 43980465, A = 1, B = 9 follows the R4 formula over several hundred samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Captures the tuning fields and restarts the phase |
| inc_i | input | 32 | Integer phase increment X |
| corr_i | input | 32 | Correction amount A |
| period_i | input | CNT_W (8) | Steps between corrections B; 0 disables correction |
| phase_o | output | 32 | Accumulated phase |
| addr_o | output | ADDR_W (12) | Truncated lookup address |
| valid_o | output | 1 | A configuration has been loaded |

## Verification
A counter that is off by one, or that does not clear on load, moves the correction to the wrong step. The phase then differs from the closed-form value at the first multiple of B, which is within nine samples for the periods used here. An error in the carry or in the width of the adder first appears on a step that wraps past 2^32. For the ten-sample case, that step is the tenth sample, which would not return to 0. The sweep over small increments, corrections and periods, including zero values, compares every sample with the formula. Each such fault therefore shows at the ports within one correction period.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  localparam int unsigned PH_W  = 32;
  localparam int unsigned CNT_W = 8;

  typedef struct packed {
    logic [PH_W-1:0]  inc;
    logic [PH_W-1:0]  corr;
    logic [CNT_W-1:0] period;
  } tune_t;
endpackage

// File: rtl/cpg_cfg_reg.sv
module cpg_cfg_reg
  import cpg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  tune_t tune_i,
  output tune_t tune_o,
  output logic  valid_o
);
  tune_t tune_q;
  logic  valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tune_q  <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      tune_q  <= tune_i;
      valid_q <= 1'b1;
    end
  end

  assign tune_o  = tune_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/cpg_corr_ctr.sv
module cpg_corr_ctr
  import cpg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             en;

  assign en     = (period_i != '0);
  assign fire_o = en && (cnt_q == period_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (!en)         cnt_q <= '0;
    else if (fire_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + CNT_W'(1);
  end

  // R4: counter stays inside the period
  a_r4_ctr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en |-> (cnt_q < period_i));
  // R4: a correction restarts the count
  a_r4_ctr_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (cnt_q == '0));
  // R7: zero period never corrects
  a_r7_no_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0) |-> !fire_o);
endmodule

// File: rtl/cpg_phase_acc.sv
module cpg_phase_acc
  import cpg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            fire_i,
  input  logic [PH_W-1:0] inc_i,
  input  logic [PH_W-1:0] corr_i,
  output logic [PH_W-1:0] phase_o
);
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] step;

  assign step = inc_i + (fire_i ? corr_i : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (clr_i)  phase_q <= '0;
    else             phase_q <= phase_q + step;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/cpg_addr_trunc.sv
module cpg_addr_trunc
  import cpg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [PH_W-1:0]   phase_i,
  output logic [ADDR_W-1:0] addr_o
);
  generate
    if (ADDR_W >= PH_W) begin : g_full
      assign addr_o = ADDR_W'(phase_i);
    end else begin : g_slice
      assign addr_o = phase_i[PH_W-1 -: ADDR_W];
    end
  endgenerate
endmodule

// File: rtl/cpg_top.sv
module cpg_top
  import cpg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [31:0]       inc_i,
  input  logic [31:0]       corr_i,
  input  logic [CNT_W-1:0]  period_i,
  output logic [31:0]       phase_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);
  tune_t tune_in, tune_q;
  logic  fire;

  assign tune_in = '{inc: inc_i, corr: corr_i, period: period_i};

  cpg_cfg_reg i_cfg (
    .clk_i, .rst_ni, .load_i,
    .tune_i (tune_in),
    .tune_o (tune_q),
    .valid_o
  );

  cpg_corr_ctr i_ctr (
    .clk_i, .rst_ni,
    .clr_i    (load_i),
    .period_i (tune_q.period),
    .fire_o   (fire)
  );

  cpg_phase_acc i_acc (
    .clk_i, .rst_ni,
    .clr_i   (load_i),
    .fire_i  (fire),
    .inc_i   (tune_q.inc),
    .corr_i  (tune_q.corr),
    .phase_o
  );

  cpg_addr_trunc #(.ADDR_W(ADDR_W)) i_trunc (
    .phase_i (phase_o),
    .addr_o
  );

  // R1: idle until first load
  a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (phase_o == '0));
  // R2: load restarts at zero and marks valid
  a_r2_load_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (phase_o == '0) && valid_o);
  // R3: each step is X or X+A
  a_r3_step_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !load_i) |=>
      ((phase_o - $past(phase_o)) == tune_q.inc) ||
      ((phase_o - $past(phase_o)) == tune_q.inc + tune_q.corr));
endmodule

// File: tb/test_cpg_top.sv
module test_cpg_top;
  localparam int unsigned ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              load_i = 1'b0;
  logic [31:0]       inc_i = '0;
  logic [31:0]       corr_i = '0;
  logic [7:0]        period_i = '0;
  logic [31:0]       phase_o;
  logic [ADDR_W-1:0] addr_o;
  logic              valid_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cpg_top #(.ADDR_W(ADDR_W)) i_cpg_top (
    .clk_i (clk), .rst_ni, .load_i, .inc_i, .corr_i, .period_i,
    .phase_o, .addr_o, .valid_o
  );

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input longint unsigned k, input longint unsigned x,
                                        input longint unsigned a, input longint unsigned b);
    longint unsigned v;
    v = k * x + ((b == 0) ? 0 : (k / b) * a);
    return v[31:0];
  endfunction

  // drives a load at a falling edge; returns at the falling edge holding sample 0
  task automatic do_load(input logic [31:0] x, input logic [31:0] a, input logic [7:0] b);
    @(negedge clk);
    load_i = 1'b1; inc_i = x; corr_i = a; period_i = b;
    @(negedge clk);
    load_i = 1'b0; inc_i = '0; corr_i = '0; period_i = '0;
  endtask

  task automatic run_cfg(input string req, input logic [31:0] x, input logic [31:0] a,
                         input logic [7:0] b, input int n);
    do_load(x, a, b);
    check("R2 valid", valid_o, 1);
    check("R2 zero", phase_o, 0);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      check(req, phase_o, model(k, x, a, b));
      check("R8", addr_o, phase_o[31 -: ADDR_W]);
    end
  endtask

  initial begin
    #2;
    check("R1 phase", phase_o, 0);
    check("R1 valid", valid_o, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 phase idle", phase_o, 0);
    check("R1 addr idle", addr_o, 0);
    check("R1 valid idle", valid_o, 0);

    // R5 worked example
    do_load(32'd429496729, 32'd3, 8'd5);
    check("R2 zero", phase_o, 0);
    for (int k = 1; k <= 200; k++) begin
      @(negedge clk);
      check("R4", phase_o, model(k, 429496729, 3, 5));
      if (k == 4) check("R5 k4", phase_o, 64'd4 * 429496729);
      if (k == 5) check("R5 k5", phase_o, 64'd5 * 429496729 + 3);
      if (k == 9) check("R5 k9", phase_o, 64'd9 * 429496729 + 3);
      if (k % 10 == 0) check("R5 wrap", phase_o, 0);
    end

    run_cfg("R9", 32'd43980465, 32'd1, 8'd9, 300);
    run_cfg("R6", 32'hDEADBEEF, 32'd0, 8'd7, 60);
    run_cfg("R7", 32'h12345678, 32'd999, 8'd0, 60);
    run_cfg("R3", 32'hF0000001, 32'h0000FFFF, 8'd3, 40);

    // R2: held strobe keeps phase at zero
    @(negedge clk);
    load_i = 1'b1; inc_i = 32'd1000; corr_i = 32'd7; period_i = 8'd2;
    repeat (4) begin
      @(negedge clk);
      check("R2 held", phase_o, 0);
    end
    load_i = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R2 after hold", phase_o, model(k, 1000, 7, 2));
    end

    // R4 mid-run reload restarts counter
    do_load(32'd50, 32'd5, 8'd4);
    repeat (3) @(negedge clk);
    run_cfg("R4 reload", 32'd50, 32'd5, 8'd4, 12);

    // sweep small configurations
    for (int b = 0; b <= 5; b++)
      for (int a = 0; a <= 3; a++)
        for (int x = 0; x <= 2; x++)
          run_cfg("R4 sweep", 32'(x * 3 + 1), 32'(a * 11), 8'(b), 24);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
      $finish;
    end
  end
endmodule